// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synchronous SRAM core with its own storage array and a two-stage pipeline. It takes at most one command per enabled clock edge: load a read, load a write, continue a burst, or deselect. Read data leaves through a registered output stage. Write data is taken two enabled edges after its address, so reads and writes can alternate on every cycle with no idle cycles between them.

A write's data is not stored in the array straight away. It waits in a pending-write register and moves into the array when the next write's data arrives. A read that targets the pending word takes the pending bytes and the array bytes merged under the stored byte mask, so it always returns the newest value.

A small burst sequencer remembers the direction and start address of the last loaded command. It has three states. `BS_IDLE` is entered on reset or on any deselect. `BS_RD` is entered when a read is loaded, and `BS_WR` when a write is loaded. From `BS_RD` or `BS_WR`, a continue command steps a 2-bit beat count and stays in the same state. In `BS_IDLE`, a continue command does nothing.

Top module: `zbt_sram`

## Requirements
- R1: The block is selected only when `ce1_n`=0, `ce2_n`=0 and `ce3`=1. Any other combination is a deselect: it does not write, it produces no read output, and it returns the sequencer to `BS_IDLE`.
- R2: A read sampled at enabled edge E presents its word on `dout` just after enabled edge E+2, and not earlier.
- R3: Byte enables `bw_n` are sampled with the address and are active low. Bit b governs `din[8b+7:8b]`. A write changes only its enabled bytes, and a write with `bw_n`=2'b11 changes nothing.
- R4: Any mix of commands on consecutive cycles stays coherent. A read returns the newest value of every byte, even when that value is still in the pending-write register.
- R5: With selection, `adv`=0 loads a command, where `rw`=1 means read and `rw`=0 means write. `adv`=1 continues the last loaded direction at the next beat. The beat count wraps after four beats and never changes `addr[ADDR_W-1:2]`.
- R6: With `mode`=0, beat k of a burst has low address bits equal to (start + k) mod 4.
- R7: With `mode`=1, beat k of a burst has low address bits equal to start XOR k.
- R8: A continue issued after reset or after a deselect, before any new load, is a no-op.
- R9: While `cen_n`=1, all state is frozen. The output holds its value, no command is accepted, and `din` is not sampled.
- R10: `dout_vld` is 1 only when `oe_n`=0 and the output stage holds a read. When `dout_vld` is 0, `dout` is all zeros.
- R11: Reset clears the array to zero, drops any pending write, and forces `dout_vld`=0 and `dout`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cen_n | input | 1 | Clock enable, active low |
| ce1_n | input | 1 | First select, active low |
| ce2_n | input | 1 | Second select, active low |
| ce3 | input | 1 | Third select, active high |
| adv | input | 1 | 1 = continue burst, 0 = load |
| rw | input | 1 | 1 = read, 0 = write (on load) |
| bw_n | input | NBYTES | Byte write enables, active low |
| mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| din | input | NBYTES*BYTE_W | Write data, two enabled edges after address |
| dout | output | NBYTES*BYTE_W | Read data, zero when not valid |
| dout_vld | output | 1 | Output carries read data |

## Verification
Two things can happen in the same cycle: a read reaches the output stage while the word it addresses is still in the pending-write register, possibly partly masked. The array then holds stale bytes, and the answer must come from the merge.

The directed vector table provokes this collision. It writes a word, then reads it straight back, and also sends two partial writes to one address back to back before reading it. A long random phase then mixes commands, deselects and stalls over only eight addresses, in both burst orders, so the collision recurs often.

Every output word is judged against a shadow memory in the bench. That memory applies writes in issue order and derives each expected read at issue time.

// File: rtl/zbt_pkg.sv
`timescale 1ns/1ps
package zbt_pkg;
    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        BS_IDLE = 2'd0,
        BS_RD   = 2'd1,
        BS_WR   = 2'd2
    } bst_e;
endpackage

// File: rtl/zbt_cmd_fsm.sv
`timescale 1ns/1ps
module zbt_cmd_fsm
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sel,
    input  logic              adv,
    input  logic              rw,
    input  logic              mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NBYTES-1:0] bw_n,
    output op_e               iss_op,
    output logic [ADDR_W-1:0] iss_addr,
    output logic [NBYTES-1:0] iss_bw_n
);
    localparam int BEAT_W = 2;

    bst_e              state, nx_state;
    logic [ADDR_W-1:0] base, nx_base;
    logic [BEAT_W-1:0] cnt, nx_cnt, step_cnt, step_lo;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= BS_IDLE;
            base  <= '0;
            cnt   <= '0;
        end else if (en) begin
            state <= nx_state;
            base  <= nx_base;
            cnt   <= nx_cnt;
        end
    end

    // next state and issued command
    always_comb begin
        nx_state = state;
        nx_base  = base;
        nx_cnt   = cnt;
        iss_op   = OP_NOP;
        iss_addr = addr;
        iss_bw_n = bw_n;
        step_cnt = cnt + 2'd1;
        step_lo  = mode ? (base[BEAT_W-1:0] ^ step_cnt)
                        : (base[BEAT_W-1:0] + step_cnt);
        if (!sel) begin
            nx_state = BS_IDLE;
        end else if (!adv) begin
            iss_op   = rw ? OP_RD : OP_WR;
            nx_state = rw ? BS_RD : BS_WR;
            nx_base  = addr;
            nx_cnt   = '0;
        end else begin
            unique case (state)
                BS_IDLE: begin
                    iss_op = OP_NOP;
                end
                BS_RD, BS_WR: begin
                    iss_op   = (state == BS_RD) ? OP_RD : OP_WR;
                    iss_addr = {base[ADDR_W-1:BEAT_W], step_lo};
                    nx_cnt   = step_cnt;
                end
                default: begin
                    nx_state = BS_IDLE;
                end
            endcase
        end
    end

    // R5: a continue in an active burst steps the beat count by one
    a_r5_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sel && adv && state != BS_IDLE) |=> cnt == $past(cnt) + 2'd1);

    // R1: a deselect returns the sequencer to idle
    a_r1_desel_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sel) |=> state == BS_IDLE);

    // R5: a continue keeps the upper address bits of the loaded start
    a_r5_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && adv && state != BS_IDLE) |->
            iss_addr[ADDR_W-1:BEAT_W] == base[ADDR_W-1:BEAT_W]);
endmodule

// File: rtl/zbt_store.sv
`timescale 1ns/1ps
module zbt_store #(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 2,
    parameter int BYTE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     wr_go,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [NBYTES-1:0]        wr_bw_n,
    input  logic [NBYTES*BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [NBYTES*BYTE_W-1:0] rd_data
);
    localparam int DATA_W = NBYTES * BYTE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              pend_v;
    logic [ADDR_W-1:0] pend_addr;
    logic [NBYTES-1:0] pend_bw_n;
    logic [DATA_W-1:0] pend_data;
    logic              pend_hit;

    // a new write retires the pending one into the array
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            pend_v    <= 1'b0;
            pend_addr <= '0;
            pend_bw_n <= '1;
            pend_data <= '0;
        end else if (en && wr_go) begin
            if (pend_v) begin
                for (int b = 0; b < NBYTES; b++) begin
                    if (!pend_bw_n[b])
                        mem[pend_addr][b*BYTE_W +: BYTE_W] <= pend_data[b*BYTE_W +: BYTE_W];
                end
            end
            pend_v    <= 1'b1;
            pend_addr <= wr_addr;
            pend_bw_n <= wr_bw_n;
            pend_data <= wr_data;
        end
    end

    assign pend_hit = pend_v && (pend_addr == rd_addr);

    // bytewise merge of the pending word over the array word
    for (genvar b = 0; b < NBYTES; b++) begin : g_fwd
        assign rd_data[b*BYTE_W +: BYTE_W] = (pend_hit && !pend_bw_n[b])
            ? pend_data[b*BYTE_W +: BYTE_W]
            : mem[rd_addr][b*BYTE_W +: BYTE_W];
    end

    // R4: an accepted write lands in the pending register
    a_r4_pend_load: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_go) |=> pend_v && pend_addr == $past(wr_addr) && pend_data == $past(wr_data));

    // R4: a full-mask pending hit is returned whole
    a_r4_full_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_hit && pend_bw_n == '0) |-> rd_data == pend_data);
endmodule

// File: rtl/zbt_sram.sv
`timescale 1ns/1ps
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 2,
    parameter int BYTE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cen_n,
    input  logic                     ce1_n,
    input  logic                     ce2_n,
    input  logic                     ce3,
    input  logic                     adv,
    input  logic                     rw,
    input  logic [NBYTES-1:0]        bw_n,
    input  logic                     mode,
    input  logic                     oe_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NBYTES*BYTE_W-1:0] din,
    output logic [NBYTES*BYTE_W-1:0] dout,
    output logic                     dout_vld
);
    localparam int DATA_W = NBYTES * BYTE_W;

    logic              en, sel;
    op_e               iss_op, s1_op, s2_op;
    logic [ADDR_W-1:0] iss_addr, s1_addr, s2_addr;
    logic [NBYTES-1:0] iss_bw_n, s1_bw_n, s2_bw_n;
    logic [DATA_W-1:0] rd_word, out_q;
    logic              out_rd;

    assign en  = !cen_n;
    assign sel = !ce1_n && !ce2_n && ce3;

    zbt_cmd_fsm #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en), .sel(sel), .adv(adv), .rw(rw),
        .mode(mode), .addr(addr), .bw_n(bw_n),
        .iss_op(iss_op), .iss_addr(iss_addr), .iss_bw_n(iss_bw_n)
    );

    zbt_store #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .en(en),
        .wr_go(s2_op == OP_WR), .wr_addr(s2_addr), .wr_bw_n(s2_bw_n),
        .wr_data(din), .rd_addr(s2_addr), .rd_data(rd_word)
    );

    // two command stages and the output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_op   <= OP_NOP;
            s1_addr <= '0;
            s1_bw_n <= '1;
            s2_op   <= OP_NOP;
            s2_addr <= '0;
            s2_bw_n <= '1;
            out_rd  <= 1'b0;
            out_q   <= '0;
        end else if (en) begin
            s1_op   <= iss_op;
            s1_addr <= iss_addr;
            s1_bw_n <= iss_bw_n;
            s2_op   <= s1_op;
            s2_addr <= s1_addr;
            s2_bw_n <= s1_bw_n;
            out_rd  <= (s2_op == OP_RD);
            if (s2_op == OP_RD) out_q <= rd_word;
        end
    end

    assign dout_vld = out_rd && !oe_n;
    assign dout     = dout_vld ? out_q : '0;

    // R9: a stalled edge leaves the pipeline and output untouched
    a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |=> $stable(s1_op) && $stable(s2_op) && $stable(out_q) && $stable(out_rd));

    // R2: stage two follows stage one by exactly one enabled edge
    a_r2_stage_move: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> s2_op == $past(s1_op) && s2_addr == $past(s1_addr));

    // R2: a read in stage two owns the output after the next enabled edge
    a_r2_read_out: assert property (@(posedge clk) disable iff (!rst_n)
        (en && s2_op == OP_RD) |=> out_rd);

    // R1: no command enters the pipeline while deselected
    a_r1_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sel) |=> s1_op == OP_NOP);
endmodule

// File: tb/test_zbt_sram.sv
`timescale 1ns/1ps
module test_zbt_sram;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cen_n = 1'b1, ce1_n = 1'b1, ce2_n = 1'b1, ce3 = 1'b0;
    logic        adv = 1'b0, rw = 1'b1, mode = 1'b0, oe_n = 1'b0;
    logic [1:0]  bw_n = 2'b11;
    logic [5:0]  addr = '0;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic        dout_vld;

    always #10 clk = ~clk;

    zbt_sram #(.ADDR_W(6), .NBYTES(2), .BYTE_W(8)) i_zbt_sram (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce1_n(ce1_n), .ce2_n(ce2_n),
        .ce3(ce3), .adv(adv), .rw(rw), .bw_n(bw_n), .mode(mode), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_vld(dout_vld)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // shadow model: ops 0 none, 1 read, 2 write
    logic [15:0] ref_mem [64];
    int          b_st;
    logic [5:0]  b_base;
    logic [1:0]  b_cnt;
    int          q1_op, q2_op;
    logic [15:0] q1_exp, q1_wd, q2_exp, q2_wd;
    bit          o_rd;
    logic [15:0] o_data;
    string       tag = "R11";

    // vector: [30] stall [29:28] desel code [27] adv [26] rw [25] mode
    //         [24] oe_n [23:22] bw_n [21:16] addr [15:0] data
    localparam int NV = 24;
    localparam logic [30:0] VEC [NV] = '{
        {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 6'd1,  16'hA1A1},
        {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 6'd2,  16'hB2B2},
        {1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 6'd0,  16'hC3C3},
        {1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 6'd1,  16'h0000},
        {1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 6'd4,  16'h0000},
        {1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 6'd0,  16'h0000},
        {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 6'd5,  16'hD5D5},
        {1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 6'd5,  16'h0000},
        {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 6'd5,  16'hEE11},
        {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 6'd5,  16'h22FF},
        {1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 6'd5,  16'h0000},
        {1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 6'd5,  16'hDEAD},
        {1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 6'd2,  16'h0000},
        {1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 6'd2,  16'h9999},
        {1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 6'd2,  16'h9999},
        {1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 6'd2,  16'h9999},
        {1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 6'd2,  16'h9999},
        {1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 6'd9,  16'h0000},
        {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 6'd1,  16'h7777},
        {1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 6'd1,  16'h0000},
        {1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 6'd1,  16'h5555},
        {1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 6'd1,  16'h5555},
        {1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 6'd0,  16'h0000},
        {1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 6'd0,  16'h0000}
    };

    task automatic chk(input bit ok, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 64; i++) ref_mem[i] = '0;
        b_st = 0; b_base = '0; b_cnt = '0;
        q1_op = 0; q2_op = 0; q1_exp = '0; q1_wd = '0; q2_exp = '0; q2_wd = '0;
        o_rd = 1'b0; o_data = '0;
    endtask

    // called at a falling edge; drives one cycle, checks after the next rising edge
    task automatic step(input bit stall, input int dsel, input bit adv_i, input bit rw_i,
                        input bit mode_i, input bit oe_i, input logic [1:0] bw_i,
                        input logic [5:0] a_i, input logic [15:0] d_i);
        int          n_op;
        logic [5:0]  n_addr;
        logic [15:0] n_exp;
        logic [1:0]  lo;
        bit          exp_v;
        cen_n = stall;
        ce1_n = (dsel == 1);
        ce2_n = (dsel == 2);
        ce3   = (dsel != 3);
        adv = adv_i; rw = rw_i; mode = mode_i; oe_n = oe_i; bw_n = bw_i; addr = a_i;
        din = (q2_op == 2) ? q2_wd : 16'($urandom);
        if (!stall) begin
            n_op = 0; n_addr = a_i; n_exp = '0;
            if (dsel != 0) begin
                b_st = 0;
            end else if (!adv_i) begin
                n_op = rw_i ? 1 : 2;
                b_st = n_op; b_base = a_i; b_cnt = 2'd0;
            end else if (b_st != 0) begin
                b_cnt = b_cnt + 2'd1;
                lo = mode_i ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt);
                n_addr = {b_base[5:2], lo};
                n_op = b_st;
            end
            if (n_op == 2) begin
                for (int b = 0; b < 2; b++)
                    if (!bw_i[b]) ref_mem[n_addr][b*8 +: 8] = d_i[b*8 +: 8];
            end
            if (n_op == 1) n_exp = ref_mem[n_addr];
            o_rd = (q2_op == 1);
            if (o_rd) o_data = q2_exp;
            q2_op = q1_op; q2_exp = q1_exp; q2_wd = q1_wd;
            q1_op = n_op;  q1_exp = n_exp;  q1_wd = d_i;
        end
        @(negedge clk);
        exp_v = o_rd && !oe_i;
        chk(dout_vld == exp_v, "dout_vld (R10)", {15'd0, dout_vld}, {15'd0, exp_v});
        chk(dout == (exp_v ? o_data : 16'h0), "dout", dout, exp_v ? o_data : 16'h0);
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d, input logic [1:0] bw);
        step(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0, bw, a, d);
    endtask
    task automatic rd(input logic [5:0] a);
        step(1'b0, 0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, a, 16'h0);
    endtask
    task automatic cont(input bit m, input logic [15:0] d);
        step(1'b0, 0, 1'b1, 1'b0, m, 1'b0, 2'b00, 6'd0, d);
    endtask
    task automatic idle(input int code);
        step(1'b0, code, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 6'd0, 16'h0);
    endtask
    task automatic hold();
        step(1'b1, 0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 6'd0, 16'hBAD0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cen_n = 1'b0; ce1_n = 1'b1; ce2_n = 1'b1; ce3 = 1'b0;
        oe_n = 1'b0; adv = 1'b0;
        @(negedge clk);
        @(negedge clk);
        tag = "R11";
        chk(dout_vld == 1'b0, "reset dout_vld", {15'd0, dout_vld}, 16'h0);
        chk(dout == 16'h0, "reset dout", dout, 16'h0);
        model_clear();
        rst_n = 1'b1;
    endtask

    initial begin
        model_clear();
        do_reset();

        // table walk: back-to-back mixes with collisions (R4)
        tag = "R4";
        for (int i = 0; i < NV; i++)
            step(VEC[i][30], int'(VEC[i][29:28]), VEC[i][27], VEC[i][26], VEC[i][25],
                 VEC[i][24], VEC[i][23:22], VEC[i][21:16], VEC[i][15:0]);

        // R2: read latency, output appears two enabled edges after the address
        tag = "R2";
        wr(6'd30, 16'h3030, 2'b00); idle(1); idle(1);
        rd(6'd30); idle(1); idle(1); idle(1);

        // R6: linear order from start 1 -> 9,10,11,8
        tag = "R6";
        for (int k = 8; k < 12; k++) wr(6'(k), 16'(16'h0800 + k), 2'b00);
        rd(6'd9); cont(1'b0, 16'h0); cont(1'b0, 16'h0); cont(1'b0, 16'h0); idle(2); idle(2);

        // R7: interleaved order from start 1 -> 9,8,11,10
        tag = "R7";
        rd(6'd9); cont(1'b1, 16'h0); cont(1'b1, 16'h0); cont(1'b1, 16'h0); idle(2); idle(2);

        // R5: burst write of five beats wraps, then read back
        tag = "R5";
        wr(6'd14, 16'hE000, 2'b00);
        for (int k = 1; k < 5; k++) cont(1'b0, 16'(16'hE000 + k));
        for (int k = 12; k < 16; k++) rd(6'(k));
        idle(3); idle(3);

        // R8: continue after a deselect or after a fresh reset does nothing
        tag = "R8";
        wr(6'd40, 16'h4040, 2'b00); idle(1); cont(1'b0, 16'hFFFF); cont(1'b0, 16'hFFFF);
        rd(6'd40); rd(6'd41); idle(1); idle(1);

        // R9: stalls between address and data, and while output is held
        tag = "R9";
        wr(6'd20, 16'h2020, 2'b00); hold(); hold(); idle(1); hold(); idle(1);
        rd(6'd20); idle(1); hold(); hold(); idle(1); idle(1);

        // R3: byte masks
        tag = "R3";
        wr(6'd21, 16'hAAAA, 2'b00); wr(6'd21, 16'h5555, 2'b11);
        wr(6'd21, 16'h1234, 2'b10); rd(6'd21); idle(1); idle(1);
        wr(6'd21, 16'h9876, 2'b01); idle(1); idle(1); rd(6'd21); idle(1); idle(1);

        // R1: writes under each deselect code are dropped
        tag = "R1";
        for (int c = 1; c < 4; c++)
            step(1'b0, c, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 6'd22, 16'(16'hC000 + c));
        rd(6'd22); idle(3); idle(3);

        // R10: output enable masks a valid read
        tag = "R10";
        rd(6'd1);
        idle(1);
        step(1'b0, 1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 6'd0, 16'h0);
        idle(1);

        // R11: reset drops a pending write and clears the array
        wr(6'd3, 16'h1357, 2'b00); idle(1); idle(1);
        do_reset();
        rd(6'd3); rd(6'd1); idle(1); idle(1);
        tag = "R8";
        cont(1'b0, 16'h0); idle(1); idle(1);

        // random mix in both burst orders
        tag = "R4";
        for (int n = 0; n < 4000; n++) begin
            automatic int r = $urandom_range(0, 99);
            automatic int ds = (r < 12) ? int'($urandom_range(1, 3)) : 0;
            step($urandom_range(0, 9) == 0, ds, $urandom_range(0, 9) < 3,
                 1'($urandom), n >= 2000, $urandom_range(0, 9) == 0,
                 2'($urandom), 6'($urandom_range(0, 7)), 16'($urandom));
        end
        idle(1); idle(1); idle(1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #3000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog %s: actual=hung expected=finished", tag);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule